// File: doc/BRIEF.md
# Configuration Command and Status Register

This block gives software three word-wide registers for sending configuration commands to the platform. A data word is held for the command. Writing the control word issues the command, and that command finishes in the same write. A two-bit status word then reports the result. Of all control values, only two are understood. One of them raises a single-cycle request to power the system down. The other raises a single-cycle request to restart it. Every other control value completes with the error bit set.

The registers exist only in one platform variant, which the `VARIANT` parameter selects. In any other variant, all three offsets behave like every unmapped offset. A read returns zero and the access is flagged as a bad address. A write changes nothing and raises no request. Accesses use a simple single-cycle strobe. Read data and the bad-address flag are registered and appear in the cycle after the strobe.

Top module: `cfg_cmd_ctrl`

## Requirements
- R1: After reset, the data, control and status registers all read as zero, and neither request output is asserted.
- R2: In the supporting variant (`VARIANT` = 3), offset 0xA0 is a 32-bit read/write data register. A read strobe returns its value on `rdata` in the following cycle, and `bad_addr` stays low.
- R3: A write to offset 0xA4 stores the write data with bits 19 and 18 forced to zero. A read of 0xA4 returns the stored value.
- R4: After any write to 0xA4, status bit 0 (done) reads as 1 at offset 0xA8. If the stored control value is one of the two known commands, the status reads exactly 1.
- R5: A stored control value of 0xC0800000 pulses `shutdown_req` in the cycle after the write. A stored value of 0xC0900000 pulses `reboot_req` in that cycle. Because R3 masking is applied first, 0xC08C0000 also counts as shutdown.
- R6: Any other stored control value gives status 3 (done plus error in bit 1), and neither request is raised.
- R7: A write to offset 0xA8 stores only bits 1:0 of the write data, and reading 0xA8 returns them zero-extended.
- R8: Each request is high for exactly one cycle per command, and the two requests are never high together.
- R9: Any offset other than the three registers is a bad address, and so are all three offsets when `VARIANT` is not 3. Such an access pulses `bad_addr` in the following cycle. A read of one returns zero, and a write to one has no effect and raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en`, zero otherwise |
| bad_addr | output | 1 | One-cycle flag for an access to an unmapped offset |
| shutdown_req | output | 1 | One-cycle power-down request |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
The bench builds two copies that share the same stimulus. One has `VARIANT` = 3, and it exercises the commands, the masking, the status encodings and the request pulses. The other has `VARIANT` = 1, where the same writes to the three offsets must stay silent and be reported as bad addresses. Running both copies on one access stream shows directly that the variant choice removes the registers completely, without disturbing any other timing.

// File: rtl/cfg_cmd_pkg.sv
package cfg_cmd_pkg;

  localparam int WORD_W = 32;
  localparam int STAT_W = 2;

  // Register offsets (byte addresses)
  localparam int OFF_DATA = 'hA0;
  localparam int OFF_CTRL = 'hA4;
  localparam int OFF_STAT = 'hA8;

  // Variant that carries the command registers
  localparam int VARIANT_WITH_CMD = 3;

  // Command codes after masking
  localparam logic [WORD_W-1:0] CODE_POWER_OFF = 32'hC080_0000;
  localparam logic [WORD_W-1:0] CODE_RESTART   = 32'hC090_0000;
  localparam logic [WORD_W-1:0] CTRL_FORCE_LOW = 32'h000C_0000;

  localparam logic [STAT_W-1:0] ST_DONE = 2'b01;
  localparam logic [STAT_W-1:0] ST_FAIL = 2'b10;

  typedef enum logic [1:0] {
    KIND_POWER_OFF = 2'd0,
    KIND_RESTART   = 2'd1,
    KIND_UNKNOWN   = 2'd2
  } cmd_kind_e;

  function automatic logic [WORD_W-1:0] ctrl_store(input logic [WORD_W-1:0] w);
    return w & ~CTRL_FORCE_LOW;
  endfunction

  function automatic cmd_kind_e classify(input logic [WORD_W-1:0] stored);
    if (stored == CODE_POWER_OFF) return KIND_POWER_OFF;
    if (stored == CODE_RESTART)   return KIND_RESTART;
    return KIND_UNKNOWN;
  endfunction

  function automatic logic [STAT_W-1:0] status_for(input cmd_kind_e k);
    return (k == KIND_UNKNOWN) ? (ST_DONE | ST_FAIL) : ST_DONE;
  endfunction

endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode #(
  parameter int ADDR_W  = 8,
  parameter bit PRESENT = 1'b1
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_data,
  output logic              sel_ctrl,
  output logic              sel_stat,
  output logic              access,
  output logic              hit
);
  import cfg_cmd_pkg::*;

  assign access = wr_en | rd_en;

  generate
    if (PRESENT) begin : g_present
      assign sel_data = (addr == ADDR_W'(OFF_DATA));
      assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
      assign sel_stat = (addr == ADDR_W'(OFF_STAT));
    end else begin : g_absent
      assign sel_data = 1'b0;
      assign sel_ctrl = 1'b0;
      assign sel_stat = 1'b0;
    end
  endgenerate

  assign hit = sel_data | sel_ctrl | sel_stat;
endmodule

// File: rtl/cfg_cmd_exec.sv
module cfg_cmd_exec (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ctrl_wr,
  input  logic [cfg_cmd_pkg::WORD_W-1:0]        wdata,
  output logic [cfg_cmd_pkg::WORD_W-1:0]        ctrl_next,
  output logic [cfg_cmd_pkg::STAT_W-1:0]        status_next,
  output logic                                  shutdown_q,
  output logic                                  reboot_q
);
  import cfg_cmd_pkg::*;

  cmd_kind_e kind;

  always_comb begin
    ctrl_next   = ctrl_store(wdata);
    kind        = classify(ctrl_next);
    status_next = status_for(kind);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shutdown_q <= 1'b0;
      reboot_q   <= 1'b0;
    end else begin
      shutdown_q <= ctrl_wr && (kind == KIND_POWER_OFF);
      reboot_q   <= ctrl_wr && (kind == KIND_RESTART);
    end
  end
endmodule

// File: rtl/cfg_cmd_regs.sv
module cfg_cmd_regs (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           sel_data,
  input  logic                           sel_ctrl,
  input  logic                           sel_stat,
  input  logic [cfg_cmd_pkg::WORD_W-1:0] wdata,
  input  logic [cfg_cmd_pkg::WORD_W-1:0] ctrl_next,
  input  logic [cfg_cmd_pkg::STAT_W-1:0] status_next,
  output logic                           ctrl_wr,
  output logic [cfg_cmd_pkg::WORD_W-1:0] data_q,
  output logic [cfg_cmd_pkg::WORD_W-1:0] ctrl_q,
  output logic [cfg_cmd_pkg::STAT_W-1:0] stat_q
);
  import cfg_cmd_pkg::*;

  assign ctrl_wr = wr_en & sel_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en && sel_data) data_q <= wdata;
      if (ctrl_wr) begin
        ctrl_q <= ctrl_next;
        stat_q <= status_next;
      end else if (wr_en && sel_stat) begin
        stat_q <= wdata[STAT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cfg_cmd_ctrl.sv
module cfg_cmd_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int VARIANT = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [cfg_cmd_pkg::WORD_W-1:0] wdata,
  output logic [cfg_cmd_pkg::WORD_W-1:0] rdata,
  output logic                           bad_addr,
  output logic                           shutdown_req,
  output logic                           reboot_req
);
  import cfg_cmd_pkg::*;

  localparam bit CFG_PRESENT = (VARIANT == VARIANT_WITH_CMD);

  logic              sel_data, sel_ctrl, sel_stat, access, hit;
  logic              ctrl_wr_evt;
  logic [WORD_W-1:0] ctrl_next, data_q, ctrl_q, rd_val;
  logic [STAT_W-1:0] status_next, stat_q;

  cfg_cmd_decode #(.ADDR_W(ADDR_W), .PRESENT(CFG_PRESENT)) u_decode (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .sel_data(sel_data), .sel_ctrl(sel_ctrl), .sel_stat(sel_stat),
    .access(access), .hit(hit)
  );

  cfg_cmd_exec u_exec (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr_evt), .wdata(wdata),
    .ctrl_next(ctrl_next), .status_next(status_next),
    .shutdown_q(shutdown_req), .reboot_q(reboot_req)
  );

  cfg_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .sel_data(sel_data), .sel_ctrl(sel_ctrl), .sel_stat(sel_stat),
    .wdata(wdata), .ctrl_next(ctrl_next), .status_next(status_next),
    .ctrl_wr(ctrl_wr_evt), .data_q(data_q), .ctrl_q(ctrl_q), .stat_q(stat_q)
  );

  always_comb begin
    rd_val = '0;
    if (sel_data) rd_val = data_q;
    if (sel_ctrl) rd_val = ctrl_q;
    if (sel_stat) rd_val = {{(WORD_W-STAT_W){1'b0}}, stat_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      bad_addr <= 1'b0;
    end else begin
      rdata    <= rd_en ? rd_val : '0;
      bad_addr <= access && !hit;
    end
  end
endmodule

// File: rtl/cfg_cmd_ctrl_chk.sv
module cfg_cmd_ctrl_chk #(
  parameter bit PRESENT = 1'b1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [cfg_cmd_pkg::WORD_W-1:0] wdata,
  input logic                           shutdown_req,
  input logic                           reboot_req,
  input logic                           ctrl_wr_evt,
  input logic [cfg_cmd_pkg::STAT_W-1:0] stat_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stat_q == 2'b00 && !shutdown_req && !reboot_req));

  // R8
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reboot_req));

  // R8
  shutdown_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);

  // R8
  reboot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req);

  // R5
  shutdown_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> ($past(ctrl_wr_evt) &&
                      (($past(wdata) & 32'hFFF3_FFFF) == 32'hC080_0000)));

  // R5
  reboot_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |-> ($past(ctrl_wr_evt) &&
                    (($past(wdata) & 32'hFFF3_FFFF) == 32'hC090_0000)));

  // R4
  status_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_evt |=> stat_q[0]);

  // R9
  absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !PRESENT |-> (!ctrl_wr_evt && !shutdown_req && !reboot_req));
endmodule

bind cfg_cmd_ctrl cfg_cmd_ctrl_chk #(.PRESENT(CFG_PRESENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdata(wdata),
  .shutdown_req(shutdown_req), .reboot_req(reboot_req),
  .ctrl_wr_evt(ctrl_wr_evt), .stat_q(stat_q)
);

// File: tb/cfg_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module cfg_cmd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_n;
  logic        bad, bad_n, shut, shut_n, reb, reb_n;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cfg_cmd_ctrl #(.ADDR_W(8), .VARIANT(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bad_addr(bad),
    .shutdown_req(shut), .reboot_req(reb));

  cfg_cmd_ctrl #(.ADDR_W(8), .VARIANT(1)) u_dut_nocfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_n), .bad_addr(bad_n),
    .shutdown_req(shut_n), .reboot_req(reb_n));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Write, then sample request pulses of both copies in the following cycle
  logic s_shut, s_reb, s_shut_n, s_reb_n, s_bad, s_bad_n;
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    s_shut = shut; s_reb = reb; s_shut_n = shut_n; s_reb_n = reb_n;
    s_bad = bad; s_bad_n = bad_n;
  endtask

  logic [31:0] r_val, r_val_n;
  task automatic rd(input logic [7:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    r_val = rdata; r_val_n = rdata_n; s_bad = bad; s_bad_n = bad_n;
  endtask

  task automatic t_reset;
    rd(8'hA0); check("R1", "data after reset", r_val, 0);
    rd(8'hA4); check("R1", "ctrl after reset", r_val, 0);
    rd(8'hA8); check("R1", "status after reset", r_val, 0);
    check("R1", "requests after reset", {30'd0, shut, reb}, 0);
  endtask

  task automatic t_data;
    wr(8'hA0, 32'hDEAD_BEEF); rd(8'hA0);
    check("R2", "data readback", r_val, 32'hDEAD_BEEF);
    check("R2", "no bad flag", {31'd0, s_bad}, 0);
    wr(8'hA0, 32'h1234_5678); rd(8'hA0);
    check("R2", "data readback 2", r_val, 32'h1234_5678);
  endtask

  task automatic t_unknown;
    wr(8'hA4, 32'hFFFF_FFFF);
    check("R6", "no request on unknown", {30'd0, s_shut, s_reb}, 0);
    rd(8'hA4); check("R3", "ctrl masked", r_val, 32'hFFF3_FFFF);
    rd(8'hA8); check("R6", "status error", r_val, 3);
  endtask

  task automatic t_shutdown;
    wr(8'hA4, 32'hC080_0000);
    check("R5", "shutdown pulse", {30'd0, s_shut, s_reb}, 2'b10);
    @(negedge clk);
    check("R8", "shutdown one cycle", {31'd0, shut}, 0);
    rd(8'hA8); check("R4", "status done", r_val, 1);
  endtask

  task automatic t_reboot;
    wr(8'hA4, 32'hC090_0000);
    check("R5", "reboot pulse", {30'd0, s_shut, s_reb}, 2'b01);
    @(negedge clk);
    check("R8", "reboot one cycle", {31'd0, reb}, 0);
    rd(8'hA8); check("R4", "status done after reboot", r_val, 1);
  endtask

  task automatic t_masked_shutdown;
    wr(8'hA4, 32'hC08C_0000);
    check("R5", "masked value shuts down", {30'd0, s_shut, s_reb}, 2'b10);
    rd(8'hA4); check("R3", "ctrl bits 19:18 cleared", r_val, 32'hC080_0000);
  endtask

  task automatic t_status_write;
    wr(8'hA8, 32'hFFFF_FFFE); rd(8'hA8);
    check("R7", "status keeps 2 bits", r_val, 2);
    wr(8'hA8, 32'h0000_0005); rd(8'hA8);
    check("R7", "status keeps 2 bits b", r_val, 1);
  endtask

  task automatic t_bad;
    rd(8'h00);
    check("R9", "unmapped read flag", {31'd0, s_bad}, 1);
    check("R9", "unmapped read zero", r_val, 0);
    wr(8'h40, 32'hC080_0000);
    check("R9", "unmapped write flag", {31'd0, s_bad}, 1);
    check("R9", "unmapped write quiet", {30'd0, s_shut, s_reb}, 0);
  endtask

  task automatic t_absent;
    wr(8'hA4, 32'hC090_0000);
    check("R9", "absent variant no request", {30'd0, s_shut_n, s_reb_n}, 0);
    check("R9", "absent variant write bad", {31'd0, s_bad_n}, 1);
    wr(8'hA0, 32'hCAFE_F00D);
    rd(8'hA0);
    check("R9", "absent variant data reads zero", r_val_n, 0);
    check("R9", "absent variant read bad", {31'd0, s_bad_n}, 1);
    rd(8'hA8);
    check("R9", "absent variant status zero", r_val_n, 0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_data;
    t_unknown;
    t_shutdown;
    t_reboot;
    t_masked_shutdown;
    t_status_write;
    t_bad;
    t_absent;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule